// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

The block compares two IEEE-754 operands and returns a four-bit condition code. Each of the operand ports is 64 bits wide. A precision select chooses between double precision, which uses all 64 bits, and single precision, which uses only the low 32 bits. Every encoding class is decoded inside the block: zeros, subnormals, infinities, and quiet and signalling NaNs. The result reports one of four relations (equal, less, greater, unordered) using a fixed flag pattern.

A mode bit picks a quiet or a signalling compare. The only difference between the two modes is when the invalid-operation exception is raised. A valid strobe launches each compare. The flags and the exception are registered, and a result valid follows the strobe one clock later. The outputs keep their values between compares.

Top module: `fcmp_flags`

## Requirements
- R1: When the operands are equal, nzcv_o is 4'b0110 (N is bit 3, Z is bit 2, C is bit 1, V is bit 0).
- R2: When operand A is less than operand B, nzcv_o is 4'b1000.
- R3: When operand A is greater than operand B, nzcv_o is 4'b0010.
- R4: When either operand is a NaN (exponent all ones, fraction nonzero), the compare is unordered and nzcv_o is 4'b0011.
- R5: Positive zero and negative zero compare as equal.
- R6: Ordering follows sign and magnitude. A negative operand is less than a positive one. When both operands are negative, the larger magnitude is the lesser value. Infinities and subnormals are ordered by their bit magnitude.
- R7: With dbl_i=0 only bits [31:0] of each operand are used, and bits [63:32] have no effect. With dbl_i=1 all 64 bits take part.
- R8: With sig_i=0 (quiet), invalid_o is raised only when an operand is a signalling NaN (top fraction bit 0).
- R9: With sig_i=1 (signalling), invalid_o is raised for any NaN operand, quiet or signalling.
- R10: valid_o goes high exactly one clock after valid_i, and nzcv_o and invalid_o update on that same edge.
- R11: While valid_i is low, nzcv_o and invalid_o hold their values.
- R12: During reset, nzcv_o, invalid_o and valid_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Launches a compare of the current operands |
| dbl_i | input | 1 | 1: double precision, 0: single precision in bits [31:0] |
| sig_i | input | 1 | 1: signalling compare, 0: quiet compare |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| nzcv_o | output | 4 | Condition flags {N,Z,C,V} |
| invalid_o | output | 1 | Invalid-operation exception for the last compare |
| valid_o | output | 1 | Result valid, one clock after valid_i |

## Verification
There is a single register stage between the inputs and the outputs. The flags, the exception and the result valid are therefore all due on the first rising edge after the strobe. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Holding behaviour is checked by changing operands with the strobe low and sampling again one and two edges later. The bench also confirms that valid_o has dropped and that the flags have not moved.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int DW     = 64;
  localparam int SW     = 32;
  localparam int S_EXP  = 8;
  localparam int S_FRAC = 23;
  localparam int D_EXP  = 11;
  localparam int D_FRAC = 52;
  localparam int MAG_W  = DW - 1;

  typedef enum logic [1:0] {REL_EQ, REL_LT, REL_GT, REL_UN} rel_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             snan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } opnd_t;

  function automatic logic [3:0] rel_to_nzcv(rel_e r);
    case (r)
      REL_EQ:  return 4'b0110;
      REL_LT:  return 4'b1000;
      REL_GT:  return 4'b0010;
      default: return 4'b0011;
    endcase
  endfunction
endpackage

// File: rtl/fcmp_class.sv
module fcmp_class
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] v_i,
  output opnd_t                 op_o
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;

  assign exp_f    = v_i[W-2 -: EXP_W];
  assign frac_f   = v_i[FRAC_W-1:0];
  assign exp_ones = &exp_f;

  always_comb begin
    op_o      = '0;
    op_o.sign = v_i[W-1];
    op_o.nan  = exp_ones & (|frac_f);
    // signalling NaN: quiet bit (top fraction bit) clear
    op_o.snan = exp_ones & (|frac_f) & ~frac_f[FRAC_W-1];
    op_o.zero = ~|v_i[W-2:0];
    op_o.mag  = MAG_W'(v_i[W-2:0]);
  end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
  import fcmp_pkg::*;
(
  input  opnd_t a_i,
  input  opnd_t b_i,
  input  logic  sig_i,
  output rel_e  rel_o,
  output logic  invalid_o
);
  logic mag_lt;

  assign mag_lt = a_i.mag < b_i.mag;

  always_comb begin
    if (a_i.nan || b_i.nan)          rel_o = REL_UN;
    else if (a_i.zero && b_i.zero)   rel_o = REL_EQ;  // +0 == -0
    else if (a_i.sign != b_i.sign)   rel_o = a_i.sign ? REL_LT : REL_GT;
    else if (a_i.mag == b_i.mag)     rel_o = REL_EQ;
    else                             rel_o = (mag_lt ^ a_i.sign) ? REL_LT : REL_GT;
  end

  assign invalid_o = sig_i ? (a_i.nan | b_i.nan) : (a_i.snan | b_i.snan);
endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
  import fcmp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          dbl_i,
  input  logic          sig_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [3:0]    nzcv_o,
  output logic          invalid_o,
  output logic          valid_o
);
  logic [DW-1:0] opnd_raw [2];
  opnd_t         op_s [2];
  opnd_t         op_d [2];
  opnd_t         op   [2];
  rel_e          rel;
  logic          inv;

  assign opnd_raw[0] = a_i;
  assign opnd_raw[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    fcmp_class #(.EXP_W(S_EXP), .FRAC_W(S_FRAC)) u_cls_s (
      .v_i (opnd_raw[g][SW-1:0]),
      .op_o(op_s[g])
    );
    fcmp_class #(.EXP_W(D_EXP), .FRAC_W(D_FRAC)) u_cls_d (
      .v_i (opnd_raw[g]),
      .op_o(op_d[g])
    );
    assign op[g] = dbl_i ? op_d[g] : op_s[g];
  end

  fcmp_relate u_rel (
    .a_i      (op[0]),
    .b_i      (op[1]),
    .sig_i    (sig_i),
    .rel_o    (rel),
    .invalid_o(inv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nzcv_o    <= '0;
      invalid_o <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        nzcv_o    <= rel_to_nzcv(rel);
        invalid_o <= inv;
      end
    end
  end

  assert_valid_lat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(nzcv_o) && $stable(invalid_o));

  assert_nan_unordered_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op[0].nan || op[1].nan) |=> nzcv_o == 4'b0011);

  assert_zero_eq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op[0].zero && op[1].zero && !op[0].nan && !op[1].nan
    |=> nzcv_o == 4'b0110);

  assert_inv_needs_nan_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && invalid_o |-> nzcv_o[0]);

  assert_quiet_qnan_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !sig_i && !op[0].snan && !op[1].snan |=> !invalid_o);

  assert_code_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (nzcv_o == 4'b0110 || nzcv_o == 4'b1000 ||
                 nzcv_o == 4'b0010 || nzcv_o == 4'b0011));
endmodule

// File: tb/fcmp_flags_tb_top.sv
module fcmp_flags_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [3:0] EQ = 4'b0110, LT = 4'b1000, GT = 4'b0010, UN = 4'b0011;

  typedef struct packed {
    logic        dbl;
    logic        sig;
    logic [63:0] a;
    logic [63:0] b;
    logic [3:0]  nzcv;
    logic        inv;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 64'h3F800000, 64'h40000000, LT, 1'b0},  // R2 single 1<2
    '{1'b0, 1'b0, 64'h40000000, 64'h3F800000, GT, 1'b0},  // R3 single 2>1
    '{1'b0, 1'b0, 64'h3F800000, 64'h3F800000, EQ, 1'b0},  // R1
    '{1'b0, 1'b0, 64'h00000000, 64'h80000000, EQ, 1'b0},  // R5 +0 vs -0
    '{1'b0, 1'b0, 64'hBF800000, 64'hC0000000, GT, 1'b0},  // R6 -1 > -2
    '{1'b0, 1'b0, 64'hC0000000, 64'hBF800000, LT, 1'b0},  // R6 -2 < -1
    '{1'b0, 1'b0, 64'hBF800000, 64'h3F800000, LT, 1'b0},  // R6 -1 < 1
    '{1'b0, 1'b0, 64'h7FC00000, 64'h3F800000, UN, 1'b0},  // R4 R8 qNaN quiet
    '{1'b0, 1'b0, 64'h3F800000, 64'h7F800001, UN, 1'b1},  // R8 sNaN quiet
    '{1'b0, 1'b1, 64'h7FC00000, 64'h3F800000, UN, 1'b1},  // R9 qNaN signalling
    '{1'b0, 1'b0, 64'h7F800000, 64'h40000000, GT, 1'b0},  // R6 inf > 2
    '{1'b0, 1'b0, 64'hFF800000, 64'h80000000, LT, 1'b0},  // R6 -inf < -0
    '{1'b0, 1'b0, 64'h00000001, 64'h00000000, GT, 1'b0},  // R6 subnormal > 0
    '{1'b0, 1'b0, 64'hFFFFFFFF_3F800000, 64'h3F800000, EQ, 1'b0},  // R7 upper ignored
    '{1'b0, 1'b1, 64'h3F800000, 64'h40000000, LT, 1'b0},  // R9 no NaN no invalid
    '{1'b1, 1'b0, 64'h3FF0000000000000, 64'h4000000000000000, LT, 1'b0},  // R2 double
    '{1'b1, 1'b0, 64'hC000000000000000, 64'h4000000000000000, LT, 1'b0},  // R6 double
    '{1'b1, 1'b0, 64'h8000000000000000, 64'h0000000000000000, EQ, 1'b0},  // R5 double
    '{1'b1, 1'b0, 64'h7FF8000000000000, 64'h3FF0000000000000, UN, 1'b0},  // R4 double qNaN
    '{1'b1, 1'b1, 64'h7FF8000000000000, 64'h3FF0000000000000, UN, 1'b1},  // R9 double
    '{1'b1, 1'b0, 64'h7FF0000000000001, 64'h3FF0000000000000, UN, 1'b1},  // R8 double sNaN
    '{1'b1, 1'b0, 64'h3FF0000000000001, 64'h3FF0000000000000, GT, 1'b0}   // R7 double low bit
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, dbl_i = 1'b0, sig_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [3:0]  nzcv_o;
  logic        invalid_o, valid_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  fcmp_flags dut_i (
    .clk_i, .rst_ni, .valid_i, .dbl_i, .sig_i, .a_i, .b_i,
    .nzcv_o, .invalid_o, .valid_o
  );

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s {valid,nzcv,inv} act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic launch(logic d, logic s, logic [63:0] a, logic [63:0] b);
    dbl_i = d; sig_i = s; a_i = a; b_i = b; valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R12", {valid_o, nzcv_o, invalid_o}, 6'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i].dbl, VECS[i].sig, VECS[i].a, VECS[i].b);
      chk($sformatf("R1-6/8/9 vec%0d", i), {valid_o, nzcv_o, invalid_o},
          {1'b1, VECS[i].nzcv, VECS[i].inv});
    end

    // R10: one-cycle latency, valid drops after single strobe
    launch(1'b0, 1'b0, 64'h40000000, 64'h3F800000);
    chk("R10 due", {valid_o, nzcv_o, invalid_o}, {1'b1, GT, 1'b0});
    @(negedge clk_i);
    chk("R10 drop", {valid_o, nzcv_o, invalid_o}, {1'b0, GT, 1'b0});

    // R11: operands change with strobe low, outputs hold
    launch(1'b0, 1'b0, 64'h7F800001, 64'h3F800000);
    chk("R11 setup", {valid_o, nzcv_o, invalid_o}, {1'b1, UN, 1'b1});
    a_i = 64'h3F800000; b_i = 64'h40000000; sig_i = 1'b1;
    @(negedge clk_i);
    chk("R11 hold1", {valid_o, nzcv_o, invalid_o}, {1'b0, UN, 1'b1});
    @(negedge clk_i);
    chk("R11 hold2", {valid_o, nzcv_o, invalid_o}, {1'b0, UN, 1'b1});

    // R7: single mode with a double NaN pattern in upper word ignored
    launch(1'b0, 1'b1, 64'h7FF80000_00000000, 64'h00000000_80000000);
    chk("R7 upper", {valid_o, nzcv_o, invalid_o}, {1'b1, EQ, 1'b0});

    // R12: reset mid-run clears outputs
    rst_ni = 1'b0;
    #1;
    chk("R12 async", {valid_o, nzcv_o, invalid_o}, 6'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule